// File: doc/BRIEF.md
# CAN Fault Confinement Counters

This block keeps the transmit error count (TEC) and receive error count (REC) of a CAN node and derives from them the node's fault confinement state: error active, error passive or bus-off. The protocol engine feeds it single-cycle events:

- transmit and receive error events;
- successful transmit and successful receive events;
- one pulse each time it sees 11 consecutive nominal recessive bits.

Control inputs select enable, soft reset, snoop (listen-only) operation, a one-shot manual recovery request and a level that permits automatic recovery.

When TEC would pass 255, the node goes bus-off. Both counters clear and a single-cycle interrupt pulse is raised. The node then waits. Once recovery is permitted, the receive counter counts idle sequences. On the 128th sequence the node returns to error active with both counters at zero, and a recovery-done pulse is raised. All outputs come from registers and change on the clock edge that consumes the event.

Top module: `can_fault_confine`

## Requirements
- R1: A synchronous soft reset, or the enable input being low, clears both counters to 0. The same clear forces the state to error active and drops any pending manual recovery request. Any event in that cycle is ignored.
- R2: While snoop is high, both counters are held at 0 whatever events arrive, and the packed counter view reads 0.
- R3: Outside bus-off, a transmit error adds 8 to TEC and a successful transmit subtracts 1 from TEC, stopping at 0. When both arrive in one cycle, the error wins.
- R4: Outside bus-off, a receive error adds 1 to REC, stopping at 255, and a successful receive subtracts 1 from REC, stopping at 0. When both arrive in one cycle, the error wins.
- R5: The state output encodes error active as 2'b00, error passive as 2'b01 and bus-off as 2'b10. The state is error passive when not bus-off and either counter is 128 or more. The value 2'b11 never appears.
- R6: The warning flag is high when either counter is 96 or more, or when the node is bus-off.
- R7: A transmit error that would take TEC above 255 moves the node to bus-off on that edge and clears both counters. Any receive event in that cycle is ignored. The bus-off interrupt is high for exactly that one cycle.
- R8: In bus-off, transmit and receive error and success events are ignored. Idle-sequence pulses are ignored until recovery is armed. A manual request given while not bus-off has no effect.
- R9: Recovery is armed by auto recovery being high, or by a manual request pulse seen in bus-off, which is latched. While armed, each idle-sequence pulse adds 1 to REC. The 128th pulse returns the node to error active with TEC = REC = 0, and the recovery-done output is high for that one cycle.
- R10: The packed counter view carries REC in bits 15:8 and TEC in bits 7:0.
- R11: If auto recovery drops with no manual request latched, counting pauses with REC held. It resumes from the held value when recovery is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enable_i | input | 1 | Node enable; low clears the counters |
| soft_rst_i | input | 1 | Synchronous soft reset |
| snoop_i | input | 1 | Listen-only mode; counters held at zero |
| auto_recov_i | input | 1 | Level that permits automatic bus-off recovery |
| start_recov_i | input | 1 | Manual recovery request pulse |
| tx_err_i | input | 1 | Error detected while transmitting |
| rx_err_i | input | 1 | Error detected while receiving |
| tx_ok_i | input | 1 | Frame transmitted successfully |
| rx_ok_i | input | 1 | Frame received successfully |
| idle11_i | input | 1 | 11 consecutive nominal recessive bits seen |
| tec_o | output | 8 | Transmit error count |
| rec_o | output | 8 | Receive error count |
| cnt_view_o | output | 16 | Packed view, REC high byte, TEC low byte |
| err_state_o | output | 2 | Fault confinement state |
| warn_o | output | 1 | Error warning flag |
| busoff_irq_o | output | 1 | Single-cycle pulse on bus-off entry |
| recov_done_o | output | 1 | Single-cycle pulse on recovery completion |

## Verification
The counters are driven with the following patterns:

- long runs of a single event type, which walk them across the warning level, the passive level and the REC ceiling;
- error and success events in the same cycle, which show which one takes priority;
- clears and snoop with events still arriving, which show that clearing dominates counting.

Bus-off is reached from TEC 248, so the exact overflow edge is exercised. Recovery is driven three ways: manual requests, auto recovery interrupted mid-count, and requests given outside bus-off or cancelled by a soft reset. Together these separate "armed" from "not armed" and show exactly where the 128th idle pulse lands.

// File: rtl/canfc_pkg.sv
package canfc_pkg;

  localparam int FC_CNT_W = 8;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUSOFF  = 2'b10
  } fc_state_e;

  // Sum one bit wider than the counter so the carry flags an overflow.
  function automatic logic [FC_CNT_W:0] fc_add_wide(input logic [FC_CNT_W-1:0] v,
                                                    input logic [FC_CNT_W:0]   inc);
    return {1'b0, v} + inc;
  endfunction

  function automatic logic [FC_CNT_W-1:0] fc_dec_sat(input logic [FC_CNT_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  function automatic logic [FC_CNT_W-1:0] fc_inc_sat(input logic [FC_CNT_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  function automatic logic fc_at_least(input logic [FC_CNT_W-1:0] v,
                                       input logic [FC_CNT_W-1:0] lvl);
    return v >= lvl;
  endfunction

endpackage

// File: rtl/canfc_tec_cnt.sv
module canfc_tec_cnt import canfc_pkg::*; #(
  parameter int TX_ERR_INC = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                hold_i,
  input  logic                err_i,
  input  logic                ok_i,
  output logic [FC_CNT_W-1:0] tec_o,
  output logic                ovf_o
);

  localparam logic [FC_CNT_W:0]   INC_W = (FC_CNT_W + 1)'(TX_ERR_INC);
  localparam logic [FC_CNT_W-1:0] INC_N = FC_CNT_W'(TX_ERR_INC);

  logic [FC_CNT_W-1:0] tec_q, tec_d;
  logic [FC_CNT_W:0]   sum_w;
  logic                err_ev_w, ok_ev_w;

  assign err_ev_w = err_i & ~hold_i & ~clr_i;
  assign ok_ev_w  = ok_i & ~err_i & ~hold_i & ~clr_i;
  assign sum_w    = fc_add_wide(tec_q, INC_W);
  assign ovf_o    = err_ev_w & sum_w[FC_CNT_W];

  always_comb begin
    tec_d = tec_q;
    if (clr_i)         tec_d = '0;
    else if (ovf_o)    tec_d = '0;
    else if (err_ev_w) tec_d = sum_w[FC_CNT_W-1:0];
    else if (ok_ev_w)  tec_d = fc_dec_sat(tec_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tec_q <= '0;
    else        tec_q <= tec_d;
  end

  assign tec_o = tec_q;

  // R3
  tec_err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_ev_w && !ovf_o) |=> (tec_o == $past(tec_o) + INC_N));

  // R3
  tec_ok_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_ev_w |=> (tec_o == fc_dec_sat($past(tec_o))));

  // R7
  tec_ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> (tec_o == '0));

endmodule

// File: rtl/canfc_rec_cnt.sv
module canfc_rec_cnt import canfc_pkg::*; #(
  parameter int RECOV_SEQ = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_i,
  input  logic                busoff_i,
  input  logic                arm_i,
  input  logic                wipe_i,
  input  logic                err_i,
  input  logic                ok_i,
  input  logic                idle_i,
  output logic [FC_CNT_W-1:0] rec_o,
  output logic                last_o
);

  localparam logic [FC_CNT_W-1:0] LAST_V = FC_CNT_W'(RECOV_SEQ - 1);

  logic [FC_CNT_W-1:0] rec_q, rec_d;
  logic                step_w;

  assign step_w = busoff_i & arm_i & idle_i & ~clr_i;
  assign last_o = step_w & (rec_q == LAST_V);

  always_comb begin
    rec_d = rec_q;
    if (clr_i || wipe_i)  rec_d = '0;
    else if (busoff_i) begin
      if (last_o)         rec_d = '0;
      else if (step_w)    rec_d = rec_q + 1'b1;
    end
    else if (err_i)       rec_d = fc_inc_sat(rec_q);
    else if (ok_i)        rec_d = fc_dec_sat(rec_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rec_q <= '0;
    else        rec_q <= rec_d;
  end

  assign rec_o = rec_q;

  // R8
  rec_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busoff_i && !arm_i && !clr_i) |=> $stable(rec_o));

  // R9
  rec_recov_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && !last_o) |=> (rec_o == $past(rec_o) + 1'b1));

  // R4
  rec_err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_i && !busoff_i && !clr_i && !wipe_i) |=> (rec_o >= $past(rec_o)));

endmodule

// File: rtl/canfc_bo_fsm.sv
module canfc_bo_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic ovf_i,
  input  logic last_i,
  input  logic start_i,
  input  logic auto_i,
  output logic busoff_o,
  output logic arm_o,
  output logic bo_irq_o,
  output logic done_o
);

  logic bo_q, req_q, irq_q, done_q;
  logic enter_w, leave_w;

  assign enter_w = ~clr_i & ~bo_q & ovf_i;
  assign leave_w = ~clr_i & bo_q & last_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bo_q   <= 1'b0;
      req_q  <= 1'b0;
      irq_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      irq_q  <= enter_w;
      done_q <= leave_w;
      if (clr_i || leave_w) bo_q <= 1'b0;
      else if (enter_w)     bo_q <= 1'b1;
      if (clr_i || leave_w)       req_q <= 1'b0;
      else if (bo_q && start_i)   req_q <= 1'b1;
    end
  end

  assign busoff_o = bo_q;
  assign arm_o    = auto_i | req_q;
  assign bo_irq_o = irq_q;
  assign done_o   = done_q;

  // R7
  bo_irq_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busoff_o) |-> bo_irq_o);

  // R7
  bo_irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bo_irq_o |=> !bo_irq_o);

  // R9
  bo_done_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busoff_o) && !$past(clr_i)) |-> done_o);

  // R8
  bo_req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busoff_o && start_i) |=> !req_q);

endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine import canfc_pkg::*; #(
  parameter int TX_ERR_INC  = 8,
  parameter int PASSIVE_LVL = 128,
  parameter int WARN_LVL    = 96,
  parameter int RECOV_SEQ   = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enable_i,
  input  logic                  soft_rst_i,
  input  logic                  snoop_i,
  input  logic                  auto_recov_i,
  input  logic                  start_recov_i,
  input  logic                  tx_err_i,
  input  logic                  rx_err_i,
  input  logic                  tx_ok_i,
  input  logic                  rx_ok_i,
  input  logic                  idle11_i,
  output logic [FC_CNT_W-1:0]   tec_o,
  output logic [FC_CNT_W-1:0]   rec_o,
  output logic [2*FC_CNT_W-1:0] cnt_view_o,
  output logic [1:0]            err_state_o,
  output logic                  warn_o,
  output logic                  busoff_irq_o,
  output logic                  recov_done_o
);

  localparam logic [FC_CNT_W-1:0] PASS_V = FC_CNT_W'(PASSIVE_LVL);
  localparam logic [FC_CNT_W-1:0] WARN_V = FC_CNT_W'(WARN_LVL);

  logic clr_w, busoff_w, arm_w, ovf_w, last_w;
  logic passive_w;
  fc_state_e state_w;

  assign clr_w = soft_rst_i | ~enable_i | snoop_i;

  canfc_tec_cnt #(.TX_ERR_INC(TX_ERR_INC)) tec_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_w),
    .hold_i (busoff_w),
    .err_i  (tx_err_i),
    .ok_i   (tx_ok_i),
    .tec_o  (tec_o),
    .ovf_o  (ovf_w)
  );

  canfc_rec_cnt #(.RECOV_SEQ(RECOV_SEQ)) rec_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr_w),
    .busoff_i (busoff_w),
    .arm_i    (arm_w),
    .wipe_i   (ovf_w),
    .err_i    (rx_err_i),
    .ok_i     (rx_ok_i),
    .idle_i   (idle11_i),
    .rec_o    (rec_o),
    .last_o   (last_w)
  );

  canfc_bo_fsm fsm_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr_w),
    .ovf_i    (ovf_w),
    .last_i   (last_w),
    .start_i  (start_recov_i),
    .auto_i   (auto_recov_i),
    .busoff_o (busoff_w),
    .arm_o    (arm_w),
    .bo_irq_o (busoff_irq_o),
    .done_o   (recov_done_o)
  );

  assign passive_w = fc_at_least(tec_o, PASS_V) | fc_at_least(rec_o, PASS_V);

  always_comb begin
    if (busoff_w)       state_w = FC_BUSOFF;
    else if (passive_w) state_w = FC_PASSIVE;
    else                state_w = FC_ACTIVE;
  end

  assign err_state_o = state_w;
  assign warn_o      = busoff_w | fc_at_least(tec_o, WARN_V) | fc_at_least(rec_o, WARN_V);
  assign cnt_view_o  = {rec_o, tec_o};

  // R2
  snoop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_i |=> (tec_o == '0 && rec_o == '0));

  // R1
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> (tec_o == '0 && rec_o == '0 && err_state_o == 2'b00));

  // R5
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_state_o != 2'b11);

  // R9
  done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recov_done_o |-> (err_state_o == 2'b00 && tec_o == '0 && rec_o == '0));

endmodule

// File: tb/can_fault_confine_tb.sv
`timescale 1ns/1ps
module can_fault_confine_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic enable_i = 1'b0, soft_rst_i = 1'b0, snoop_i = 1'b0, auto_recov_i = 1'b0;
  logic start_recov_i = 1'b0, tx_err_i = 1'b0, rx_err_i = 1'b0;
  logic tx_ok_i = 1'b0, rx_ok_i = 1'b0, idle11_i = 1'b0;
  logic [7:0]  tec_o, rec_o;
  logic [15:0] cnt_view_o;
  logic [1:0]  err_state_o;
  logic        warn_o, busoff_irq_o, recov_done_o;

  can_fault_confine dut_i (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .soft_rst_i(soft_rst_i),
    .snoop_i(snoop_i), .auto_recov_i(auto_recov_i), .start_recov_i(start_recov_i),
    .tx_err_i(tx_err_i), .rx_err_i(rx_err_i), .tx_ok_i(tx_ok_i), .rx_ok_i(rx_ok_i),
    .idle11_i(idle11_i), .tec_o(tec_o), .rec_o(rec_o), .cnt_view_o(cnt_view_o),
    .err_state_o(err_state_o), .warn_o(warn_o), .busoff_irq_o(busoff_irq_o),
    .recov_done_o(recov_done_o)
  );

  int n_chk = 0, n_err = 0;
  bit done_flag = 0;

  int m_tec = 0, m_rec = 0, m_bo = 0, m_req = 0, m_irq = 0, m_done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference, updated once per rising edge.
  always @(posedge clk) begin
    int armed;
    m_irq = 0;
    m_done = 0;
    if (!rst_n || soft_rst_i || !enable_i || snoop_i) begin
      m_tec = 0; m_rec = 0; m_bo = 0; m_req = 0;
    end else if (m_bo != 0) begin
      armed = (auto_recov_i || m_req != 0) ? 1 : 0;
      if (start_recov_i) m_req = 1;
      if (armed != 0 && idle11_i) begin
        m_rec = m_rec + 1;
        if (m_rec == 128) begin
          m_bo = 0; m_rec = 0; m_tec = 0; m_req = 0; m_done = 1;
        end
      end
    end else begin
      if (tx_err_i && m_tec + 8 > 255) begin
        m_bo = 1; m_tec = 0; m_rec = 0; m_irq = 1;
      end else begin
        if (tx_err_i) m_tec = m_tec + 8;
        else if (tx_ok_i && m_tec > 0) m_tec = m_tec - 1;
        if (rx_err_i) begin
          if (m_rec < 255) m_rec = m_rec + 1;
        end else if (rx_ok_i && m_rec > 0) m_rec = m_rec - 1;
      end
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      int exp_state;
      exp_state = (m_bo != 0) ? 2 : ((m_tec >= 128 || m_rec >= 128) ? 1 : 0);
      chk("R3 tec", int'(tec_o), m_tec);
      chk("R4 rec", int'(rec_o), m_rec);
      chk("R5 state", int'(err_state_o), exp_state);
      chk("R6 warn", int'(warn_o), (m_bo != 0 || m_tec >= 96 || m_rec >= 96) ? 1 : 0);
      chk("R7 busoff irq", int'(busoff_irq_o), m_irq);
      chk("R9 recovery done", int'(recov_done_o), m_done);
      chk("R10 view", int'(cnt_view_o), m_rec * 256 + m_tec);
    end
  end

  task automatic drive(input logic te, input logic to, input logic re,
                       input logic ro, input logic id, input logic st);
    tx_err_i = te; tx_ok_i = to; rx_err_i = re; rx_ok_i = ro;
    idle11_i = id; start_recov_i = st;
    @(negedge clk);
    tx_err_i = 0; tx_ok_i = 0; rx_err_i = 0; rx_ok_i = 0;
    idle11_i = 0; start_recov_i = 0;
  endtask

  task automatic go_busoff();
    repeat (32) drive(1, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    enable_i = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset tec", int'(tec_o), 0);
    chk("R1 reset rec", int'(rec_o), 0);
    chk("R1 reset state", int'(err_state_o), 0);

    // R3 / R6 / R5 transmit counting
    repeat (12) drive(1, 0, 0, 0, 0, 0);
    chk("R3 tec after 12 errors", int'(tec_o), 96);
    chk("R6 warn at 96", int'(warn_o), 1);
    repeat (4) drive(1, 0, 0, 0, 0, 0);
    chk("R5 passive at 128", int'(err_state_o), 1);
    drive(1, 1, 0, 0, 0, 0);
    chk("R3 error wins over ok", int'(tec_o), 136);
    repeat (10) drive(0, 1, 0, 0, 0, 0);
    chk("R5 active below 128", int'(err_state_o), 0);

    // R4 receive counting and saturation
    repeat (300) drive(0, 0, 1, 0, 0, 0);
    chk("R4 rec saturates", int'(rec_o), 255);
    drive(0, 0, 1, 1, 0, 0);
    chk("R4 error wins over ok", int'(rec_o), 255);
    drive(0, 0, 0, 1, 0, 0);
    chk("R4 rec decrement", int'(rec_o), 254);

    // R1 soft reset and disable
    soft_rst_i = 1; drive(1, 0, 1, 0, 0, 0); soft_rst_i = 0;
    chk("R1 soft reset tec", int'(tec_o), 0);
    chk("R1 soft reset rec", int'(rec_o), 0);
    repeat (5) drive(1, 0, 0, 0, 0, 0);
    enable_i = 0; drive(1, 0, 1, 0, 0, 0); enable_i = 1;
    chk("R1 disable clears tec", int'(tec_o), 0);
    repeat (300) drive(0, 0, 0, 1, 0, 0);
    chk("R4 rec floor at zero", int'(rec_o), 0);

    // R2 snoop
    snoop_i = 1;
    repeat (6) drive(1, 0, 1, 0, 0, 0);
    chk("R2 snoop view", int'(cnt_view_o), 0);
    snoop_i = 0;

    // R7 / R8 / R9 manual recovery
    repeat (5) drive(0, 0, 1, 0, 0, 0);
    repeat (31) drive(1, 0, 0, 0, 0, 0);
    chk("R3 tec at 248", int'(tec_o), 248);
    drive(0, 0, 0, 0, 0, 1);
    drive(1, 0, 1, 0, 0, 0);
    chk("R7 bus-off state", int'(err_state_o), 2);
    chk("R7 irq pulse", int'(busoff_irq_o), 1);
    chk("R7 rec cleared", int'(rec_o), 0);
    drive(0, 0, 0, 0, 0, 0);
    chk("R7 irq single cycle", int'(busoff_irq_o), 0);
    repeat (10) drive(0, 0, 0, 0, 1, 0);
    chk("R8 idle ignored when unarmed", int'(rec_o), 0);
    drive(1, 0, 1, 0, 0, 0);
    drive(0, 1, 0, 1, 0, 0);
    chk("R8 events ignored tec", int'(tec_o), 0);
    chk("R8 events ignored rec", int'(rec_o), 0);
    drive(0, 0, 0, 0, 0, 1);
    repeat (127) drive(0, 0, 0, 0, 1, 0);
    chk("R9 rec at 127", int'(rec_o), 127);
    chk("R9 still bus-off", int'(err_state_o), 2);
    drive(0, 0, 0, 0, 1, 0);
    chk("R9 back to active", int'(err_state_o), 0);
    chk("R9 done pulse", int'(recov_done_o), 1);

    // R11 automatic recovery with a pause
    go_busoff();
    auto_recov_i = 1;
    repeat (50) drive(0, 0, 0, 0, 1, 0);
    auto_recov_i = 0;
    repeat (20) drive(0, 0, 0, 0, 1, 0);
    chk("R11 paused rec", int'(rec_o), 50);
    auto_recov_i = 1;
    repeat (78) drive(0, 0, 0, 0, 1, 0);
    chk("R11 resumed to active", int'(err_state_o), 0);
    auto_recov_i = 0;

    // R1 soft reset drops a pending request
    go_busoff();
    drive(0, 0, 0, 0, 0, 1);
    soft_rst_i = 1; drive(0, 0, 0, 0, 0, 0); soft_rst_i = 0;
    chk("R1 soft reset leaves bus-off", int'(err_state_o), 0);
    go_busoff();
    repeat (5) drive(0, 0, 0, 0, 1, 0);
    chk("R1 request dropped", int'(rec_o), 0);
    soft_rst_i = 1; drive(0, 0, 0, 0, 0, 0); soft_rst_i = 0;

    // R10 packed view
    repeat (3) drive(1, 0, 0, 0, 0, 0);
    repeat (5) drive(0, 0, 1, 0, 0, 0);
    chk("R10 packed view", int'(cnt_view_o), 5 * 256 + 24);

    drive(0, 0, 0, 0, 0, 0);
    finish_run();
  end

endmodule